// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one parallel character into an asynchronous serial frame on a single line. The frame shape comes from a 7-bit line-control word. It sets the character length (5 to 8 bits), parity on or off, odd or even or constant ("stick") parity, one or extended stop time, and a break override that pulls the line low. The 16x bit-rate enable comes from outside the block. Sixteen enables make one bit time.

A character is written into a one-entry holding stage with a load strobe. The control word is captured at that moment, so the word can change while earlier characters are still being sent. When the serializer is free, it takes the held character and starts the frame. A held character that is waiting starts straight after the last stop tick of the current frame, with no idle gap. Break is the only control that acts on the line at once. While break is set, serialization carries on underneath it.

Top module: `serial_char_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is clear, `txd` is 1, `busy` is 0 and `hold_empty` is 1.
- R2: A frame starts with one low start bit. The data bits follow, least significant bit first. The count of data bits is 5 + `line_ctrl[1:0]` (00→5, 01→6, 10→7, 11→8). Higher data bits are not sent.
- R3: When `line_ctrl[3]` is 1, one parity bit is sent between the last data bit and the first stop bit. When `line_ctrl[3]` is 0, no parity bit is sent.
- R4: With parity on and `line_ctrl[5]` at 0, `line_ctrl[4]`=0 makes the count of ones in the data bits plus the parity bit odd. `line_ctrl[4]`=1 makes that count even.
- R5: With parity on and `line_ctrl[5]`=1, the parity bit is the constant inverse of `line_ctrl[4]`, whatever the data.
- R6: The stop level is high and lasts 16 enables when `line_ctrl[2]`=0. When `line_ctrl[2]`=1, it lasts 24 enables for 5-bit characters and 32 enables otherwise.
- R7: Every start, data and parity bit lasts exactly 16 enables. Cycles without `bit_tick` do not advance the frame.
- R8: While `line_ctrl[6]`=1, `txd` is 0 in the same cycle. The frame keeps advancing. When break is released, `txd` shows the level the frame has reached at that time.
- R9: The control word is sampled together with the data on the load strobe. Later changes to `line_ctrl[5:0]` do not alter a frame that is already loaded.
- R10: `load` is accepted only while `hold_empty` is 1, and `hold_empty` falls in the next cycle. A load while the holding stage is full is ignored. A held character starts right after the last stop enable of the running frame.
- R11: `busy` rises one cycle after a character is held while the serializer is free, together with the start bit. `hold_empty` returns to 1 in that same cycle. `busy` falls after the final stop enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | 16x bit-rate enable |
| load | input | 1 | Write strobe for the holding stage |
| load_data | input | 8 | Character to send |
| line_ctrl | input | 7 | Frame format word; bit 6 is break |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |
| hold_empty | output | 1 | Holding stage can accept a character |

## Verification
A wrong internal state shows up on `txd` within one bit time as a wrong level. A stuck phase or a bad tick count instead shows up as a frame that is shorter or longer in enables, seen on the falling edge of `busy`. For this reason the bench compares `txd` in every cycle against a waveform built from the requirements, and it measures each frame length in enables. It does this for all 64 format codes and several data patterns. Faults in the handshake appear within two cycles of `load`, on `hold_empty` and `busy`.

// File: rtl/stx_pkg.sv
// Shared types and helpers for the serial character transmitter.
// Assumes a fixed 8-bit character field with a 2-bit length code.
package stx_pkg;
    localparam int CHAR_W   = 8;
    localparam int MIN_BITS = CHAR_W - 3;
    localparam int CTRL_W   = 7;
    localparam int BRK_BIT  = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_t;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       long_stop;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } frame_cfg_t;

    // Split the control word into frame fields.
    function automatic frame_cfg_t decode_cfg(input logic [CTRL_W-1:0] w);
        frame_cfg_t c;
        c.len_sel   = w[1:0];
        c.long_stop = w[2];
        c.par_en    = w[3];
        c.par_even  = w[4];
        c.par_stick = w[5];
        return c;
    endfunction

    // Parity bit for the active data bits of a character.
    function automatic logic calc_parity(input frame_cfg_t c, input logic [CHAR_W-1:0] d);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < MIN_BITS + int'(c.len_sel)) acc = acc ^ d[i];
        end
        if (c.par_stick) return ~c.par_even;
        return c.par_even ? acc : ~acc;
    endfunction
endpackage

// File: rtl/stx_hold.sv
// One-entry holding stage. Captures a character and its decoded format
// on load while empty, and releases it on take. It assumes that take is
// only raised while the stage holds a character.
module stx_hold
    import stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    input  logic [CTRL_W-1:0] load_ctrl,
    input  logic              take,
    output logic              valid,
    output logic [CHAR_W-1:0] data_q,
    output frame_cfg_t        cfg_q
);
    logic accept;

    assign accept = load && !valid;

    // Occupancy flag: set on an accepted load, cleared when taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid <= 1'b0;
        else if (accept) valid <= 1'b1;
        else if (take)   valid <= 1'b0;
    end

    // Payload capture: data and format are sampled together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cfg_q  <= '0;
        end else if (accept) begin
            data_q <= load_data;
            cfg_q  <= decode_cfg(load_ctrl);
        end
    end
endmodule

// File: rtl/stx_tick_timer.sv
// Counts bit-rate enables inside one frame phase. The done output pulses
// on the enable that completes limit ticks. It assumes limit is at least 1.
module stx_tick_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_zero,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = tick && !hold_zero && (cnt_q == limit - 1'b1);

    // Tick counter: held at zero when idle, wraps at phase end.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (hold_zero || done) cnt_q <= '0;
        else if (tick)              cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/stx_shifter.sv
// Frame sequencer: start, data (LSB first), optional parity, stop. It takes
// a held character when idle, or on the last stop tick for back-to-back
// frames. The line output is the unbroken level; break is applied above.
module stx_shifter
    import stx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_valid,
    input  logic [CHAR_W-1:0] hold_data,
    input  frame_cfg_t        hold_cfg,
    output logic              take,
    output logic              line,
    output logic              busy
);
    localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);
    localparam int IDX_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] T_BIT  = CNT_W'(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] T_HALF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
    localparam logic [CNT_W-1:0] T_TWO  = CNT_W'(2 * TICKS_PER_BIT);

    phase_t            phase_q;
    logic [CHAR_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic              par_q;
    logic              par_en_q;
    logic [CNT_W-1:0]  stop_lim_q;
    logic [CNT_W-1:0]  limit;
    logic              done;
    logic              idle;
    logic [IDX_W-1:0]  ld_last;
    logic [CNT_W-1:0]  ld_stop;
    logic              ld_par;

    assign idle = (phase_q == PH_IDLE);
    assign busy = !idle;
    assign take = hold_valid && (idle || (phase_q == PH_STOP && done));

    // Per-phase tick budget: stop phase uses the captured stop length.
    assign limit = (phase_q == PH_STOP) ? stop_lim_q : T_BIT;

    // Values to capture from the holding stage at take.
    always_comb begin
        ld_last = IDX_W'(MIN_BITS - 1) + IDX_W'(hold_cfg.len_sel);
        ld_par  = calc_parity(hold_cfg, hold_data);
        if (!hold_cfg.long_stop)          ld_stop = T_BIT;
        else if (hold_cfg.len_sel == 2'd0) ld_stop = T_HALF;
        else                              ld_stop = T_TWO;
    end

    stx_tick_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_zero(idle),
        .tick     (tick),
        .limit    (limit),
        .done     (done)
    );

    // Phase sequencing and shift register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            shreg_q    <= '0;
            idx_q      <= '0;
            last_q     <= '0;
            par_q      <= 1'b0;
            par_en_q   <= 1'b0;
            stop_lim_q <= T_BIT;
        end else if (take) begin
            phase_q    <= PH_START;
            shreg_q    <= hold_data;
            idx_q      <= '0;
            last_q     <= ld_last;
            par_q      <= ld_par;
            par_en_q   <= hold_cfg.par_en;
            stop_lim_q <= ld_stop;
        end else if (done) begin
            unique case (phase_q)
                PH_START: begin
                    phase_q <= PH_DATA;
                    idx_q   <= '0;
                end
                PH_DATA: begin
                    shreg_q <= shreg_q >> 1;
                    if (idx_q == last_q) phase_q <= par_en_q ? PH_PARITY : PH_STOP;
                    else                 idx_q   <= idx_q + 1'b1;
                end
                PH_PARITY: phase_q <= PH_STOP;
                PH_STOP:   phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // Unbroken line level for the current phase.
    always_comb begin
        unique case (phase_q)
            PH_START:  line = 1'b0;
            PH_DATA:   line = shreg_q[0];
            PH_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end
endmodule

// File: rtl/serial_char_tx.sv
// Top of the serial character transmitter. It joins the holding stage and
// the frame sequencer, and applies the live break override to the line.
// It assumes bit_tick is a single-cycle enable at 16x the bit rate.
module serial_char_tx
    import stx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    input  logic [CTRL_W-1:0] line_ctrl,
    output logic              txd,
    output logic              busy,
    output logic              hold_empty
);
    logic              hold_valid;
    logic [CHAR_W-1:0] hold_data;
    frame_cfg_t        hold_cfg;
    logic              take;
    logic              shift_line;

    stx_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_data(load_data),
        .load_ctrl(line_ctrl),
        .take     (take),
        .valid    (hold_valid),
        .data_q   (hold_data),
        .cfg_q    (hold_cfg)
    );

    stx_shifter #(
        .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .hold_valid(hold_valid),
        .hold_data (hold_data),
        .hold_cfg  (hold_cfg),
        .take      (take),
        .line      (shift_line),
        .busy      (busy)
    );

    assign hold_empty = !hold_valid;
    assign txd        = shift_line && !line_ctrl[BRK_BIT];
endmodule

// File: rtl/serial_char_tx_chk.sv
// Protocol checker for serial_char_tx, attached with bind. It watches the
// ports and the unbroken line level of the sequencer.
module serial_char_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic load,
    input logic brk,
    input logic txd,
    input logic busy,
    input logic hold_empty,
    input logic line
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk) |-> txd);
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!txd || brk));
    assert_stop_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(line));
    assert_no_tick_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(line));
    assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);
    assert_fill_on_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_empty) |-> $past(load));
    assert_hand_over_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hold_empty) |=> busy);
    assert_busy_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!hold_empty));
endmodule

bind serial_char_tx serial_char_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bit_tick),
    .load      (load),
    .brk       (line_ctrl[6]),
    .txd       (txd),
    .busy      (busy),
    .hold_empty(hold_empty),
    .line      (shift_line)
);

// File: tb/serial_char_tx_tb.sv
module serial_char_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_data = '0;
    logic [6:0] line_ctrl = '0;
    logic       txd, busy, hold_empty;
    int         n_tests = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    serial_char_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .load(load),
        .load_data(load_data), .line_ctrl(line_ctrl),
        .txd(txd), .busy(busy), .hold_empty(hold_empty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Frame length in enables (R3, R6, R7).
    function automatic int frame_ticks(input logic [6:0] c);
        int stop;
        stop = !c[2] ? 16 : (c[1:0] == 2'd0 ? 24 : 32);
        return 16 * (1 + 5 + int'(c[1:0]) + int'(c[3])) + stop;
    endfunction

    // Expected unbroken level at enable index k (R2..R6).
    function automatic logic exp_level(input logic [6:0] c, input logic [7:0] d, input int k);
        int n, j, ones;
        logic p;
        n = 5 + int'(c[1:0]);
        if (k < 16) return 1'b0;
        j = (k - 16) / 16;
        if (j < n) return d[j];
        if (c[3] && j == n) begin
            ones = 0;
            for (int i = 0; i < n; i++) ones += int'(d[i]);
            if (c[5]) p = ~c[4];
            else if (c[4]) p = logic'(ones % 2);
            else p = ~logic'(ones % 2);
            return p;
        end
        return 1'b1;
    endfunction

    task automatic run_frame(input logic [6:0] c, input logic [7:0] d, input int per,
                             input int brk_at, input int brk_len, input bit scramble,
                             input string req);
        int  k, cyc, ma, me;
        bit  mism, brk;
        logic e;
        @(negedge clk);
        line_ctrl = c; load_data = d; load = 1'b1; bit_tick = 1'b0;
        @(negedge clk);
        load = 1'b0;
        chk(hold_empty == 1'b0, "R10", "hold_empty after load", int'(hold_empty), 0);
        if (scramble) line_ctrl = {1'b0, ~c[5:0]};
        @(negedge clk);
        chk(busy == 1'b1, "R11", "busy after take", int'(busy), 1);
        chk(hold_empty == 1'b1, "R11", "hold_empty after take", int'(hold_empty), 1);
        k = 0; cyc = 0; mism = 0; brk = 0; ma = 0; me = 0;
        while (busy && cyc < 5000) begin
            e = brk ? 1'b0 : exp_level(c, d, k);
            if (txd !== e && !mism) begin
                mism = 1; ma = int'(txd); me = int'(e);
                $display("  mismatch ctrl=%h data=%h tick=%0d", c, d, k);
            end
            if (brk_len > 0 && cyc == brk_at) begin line_ctrl[6] = 1'b1; brk = 1; end
            if (brk && cyc == brk_at + brk_len) begin line_ctrl[6] = 1'b0; brk = 0; end
            bit_tick = (cyc % per == 0);
            if (bit_tick) k++;
            cyc++;
            @(negedge clk);
        end
        bit_tick = 1'b0;
        chk(!mism, req, "line waveform", ma, me);
        chk(k == frame_ticks(c), req, "frame length in enables", k, frame_ticks(c));
        chk(txd == 1'b1, "R1", "idle line after frame", int'(txd), 1);
    endtask

    initial begin
        #760000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int k, cyc, ma, me;
        bit mism;
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
        chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        chk(hold_empty == 1'b1, "R1", "reset hold_empty", int'(hold_empty), 1);

        // Sweep all format codes (R2, R3, R4, R5, R6) with several data patterns.
        for (int c = 0; c < 64; c++) begin
            run_frame(7'(c), 8'hD3, 1, 0, 0, 0, "R2");
            run_frame(7'(c), 8'h2C ^ 8'(c), 1, 0, 0, 0, "R4");
            run_frame(7'(c), 8'hFF, 1, 0, 0, 0, "R5");
        end
        run_frame(7'h04, 8'h15, 1, 0, 0, 0, "R6");
        run_frame(7'h08, 8'h00, 1, 0, 0, 0, "R3");

        // Sparse enables (R7).
        run_frame(7'h0F, 8'h6B, 3, 0, 0, 0, "R7");
        run_frame(7'h04, 8'h0A, 5, 0, 0, 0, "R7");

        // Control word changed after load (R9).
        run_frame(7'h3B, 8'hC4, 1, 0, 0, 1, "R9");
        run_frame(7'h0C, 8'h71, 1, 0, 0, 1, "R9");

        // Break mid-frame and across the stop bits (R8).
        run_frame(7'h1B, 8'h96, 1, 30, 45, 0, "R8");
        run_frame(7'h07, 8'h3C, 2, 250, 60, 0, "R8");

        // Break while idle (R8).
        @(negedge clk); line_ctrl = 7'h40;
        @(negedge clk);
        chk(txd == 1'b0, "R8", "idle break txd", int'(txd), 0);
        chk(busy == 1'b0, "R8", "idle break busy", int'(busy), 0);
        line_ctrl = 7'h03;
        @(negedge clk);
        chk(txd == 1'b1, "R8", "release idle break", int'(txd), 1);

        // Back-to-back frames and load while full (R10).
        line_ctrl = 7'h03; load_data = 8'hA1; load = 1'b1;
        @(negedge clk); load = 1'b0;
        @(negedge clk);
        load_data = 8'h5E; load = 1'b1;
        @(negedge clk); load = 1'b0;
        chk(hold_empty == 1'b0, "R10", "second char held", int'(hold_empty), 0);
        load_data = 8'hFF; load = 1'b1;
        @(negedge clk); load = 1'b0;
        k = 0; cyc = 0; mism = 0; ma = 0; me = 0;
        while (busy && cyc < 5000) begin
            e = (k < 160) ? exp_level(7'h03, 8'hA1, k) : exp_level(7'h03, 8'h5E, k - 160);
            if (txd !== e && !mism) begin mism = 1; ma = int'(txd); me = int'(e); end
            bit_tick = 1'b1;
            k++; cyc++;
            @(negedge clk);
        end
        bit_tick = 1'b0;
        chk(!mism, "R10", "back-to-back waveform", ma, me);
        chk(k == 320, "R10", "back-to-back length", k, 320);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10", "ignored load sent nothing", int'(busy), 0);
        chk(hold_empty == 1'b1, "R10", "hold empty at end", int'(hold_empty), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule